// File: doc/BRIEF.md
# Receive DMA Channel with Descriptor Ring

This block is one receive channel of a packet DMA engine. Software builds a ring of 8-byte descriptors in memory. Each descriptor gives a buffer address, the buffer capacity in bytes and a status half-word. The channel walks that ring, fills each buffer with one packet from a byte-wide valid/ready stream, and then writes the descriptor back with the received byte count and updated status.

Ownership of a descriptor passes through status bit 15. Software sets the bit to lend the buffer to the channel, and the channel clears it to return the filled buffer. The last descriptor of the ring carries a wrap flag, so there is no ring-size register. When the channel meets a descriptor it does not own while a packet is waiting, it turns its own enable off and leaves the packet in the stream. Software restarts it by setting the enable bit again.

A small register port holds the enable bit, two halt requests and the ring start address. Memory is reached through a word-wide request/acknowledge port with big-endian byte order.

Top module: `rxdma_channel`

## Requirements
- R1: After reset, the configuration register reads 0, the ring start register reads 0, `s_ready` is low and `mem_req` is low.
- R2: Register index 0 is the configuration register: bit 0 is enable, bit 1 is packet halt, bit 2 is burst halt. Register index 1 holds the ring start address. Writing index 1 moves the descriptor pointer to that address. Both registers read back what was written, except for bits the channel clears.
- R3: A descriptor at byte address D is two words. The word at D holds the capacity in bits [31:16] and the status in bits [15:0]. The word at D+4 holds the buffer address. The channel fetches a descriptor only when enable is set and `s_valid` is high.
- R4: Packet byte k is stored at buffer address + 4*(k/4), in bits [31-8*(k%4) -: 8] of that word, with `mem_be` bit 3-(k%4) set. A final partial word enables only the bytes it carries, so the other bytes in memory are kept.
- R5: After the last buffer write, the channel makes one full-word write at D of {byte count, status}. In that status, bit 15 is clear, bits 14 and 13 are set, bit 0 is the overflow flag, and every other bit keeps its fetched value.
- R6: After the write-back, the pointer moves to D+8. If status bit 12 was set, it moves to the ring start address instead.
- R7: If the fetched descriptor has bit 15 clear, enable reads 0 afterwards. The channel makes no memory write, keeps `s_ready` low and leaves its pointer on that descriptor, so that descriptor is used once enable is set again.
- R8: Bytes beyond the capacity are still accepted but are thrown away. The written-back count equals the capacity, and status bit 0 is set.
- R9: With packet halt set, the packet in progress completes, including its write-back. Enable then reads 0 and the channel fetches nothing more while `s_valid` is held high.
- R10: With burst halt set, the channel stops as soon as the buffer word write in progress completes. It makes no write-back, leaves ownership with itself and enable reads 0.
- R11: `s_ready` is high only while the channel waits for packet bytes, and never while a memory request is open.
- R12: Once a memory request is raised, it stays raised with the same address, direction and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the last byte of a packet |
| s_ready | output | 1 | Channel accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data, big-endian |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong descriptor pointer shows up in the next packet: its bytes land in a different buffer and a different descriptor gets written back, so the check on memory after that packet catches it. A wrong byte count or overflow flag is visible in the written-back word as soon as the packet ends. A lost or stuck ownership or enable decision shows within a few cycles as `s_ready` rising when it should stay low, or as the configuration register reading back the wrong enable. The halt tests check the descriptor word and the buffer words at the exact boundary where the channel must stop.

// File: rtl/rxdma_pkg.sv
// Shared constants and types for the receive DMA channel.
// Assumes a 32-bit memory word and a descriptor made of two such words.
package rxdma_pkg;

    localparam int BYTE_W    = 8;
    // Status half-word bit positions (software decodes these)
    localparam int ST_OVF    = 0;
    localparam int ST_WRAP   = 12;
    localparam int ST_SOP    = 13;
    localparam int ST_EOP    = 14;
    localparam int ST_OWN    = 15;
    // Configuration register bit positions
    localparam int CFG_EN    = 0;
    localparam int CFG_PHALT = 1;
    localparam int CFG_BHALT = 2;
    // Register indices
    localparam int IDX_CFG   = 0;
    localparam int IDX_RING  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HDR,
        ST_FETCH_PTR,
        ST_RECV,
        ST_WRITE,
        ST_WBACK
    } rx_state_t;

endpackage

// File: rtl/rxdma_regs.sv
// Register file of the channel: enable, the two halt requests and the ring
// start address. Assumes the engine raises stop_i for one cycle when it stops;
// a software write in the same cycle takes precedence.
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              stop_i,
    output logic              en_o,
    output logic              pkt_halt_o,
    output logic              brst_halt_o,
    output logic [ADDR_W-1:0] ring_start_o,
    output logic              ring_load_o
);

    logic wr_cfg;
    logic wr_ring;

    assign wr_cfg  = reg_wr && (reg_addr == REG_AW'(IDX_CFG));
    assign wr_ring = reg_wr && (reg_addr == REG_AW'(IDX_RING));

    // Configuration bits: software write, engine stop, halts dropped when off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o        <= 1'b0;
            pkt_halt_o  <= 1'b0;
            brst_halt_o <= 1'b0;
        end else if (wr_cfg) begin
            en_o        <= reg_wdata[CFG_EN];
            pkt_halt_o  <= reg_wdata[CFG_PHALT];
            brst_halt_o <= reg_wdata[CFG_BHALT];
        end else if (stop_i || !en_o) begin
            en_o        <= 1'b0;
            pkt_halt_o  <= 1'b0;
            brst_halt_o <= 1'b0;
        end
    end

    // Ring start address and a one-cycle pointer load pulse after a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_start_o <= '0;
            ring_load_o  <= 1'b0;
        end else begin
            ring_load_o <= wr_ring;
            if (wr_ring) begin
                ring_start_o <= reg_wdata[ADDR_W-1:0];
            end
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(IDX_CFG)) begin
            reg_rdata[CFG_EN]    = en_o;
            reg_rdata[CFG_PHALT] = pkt_halt_o;
            reg_rdata[CFG_BHALT] = brst_halt_o;
        end else if (reg_addr == REG_AW'(IDX_RING)) begin
            reg_rdata = REG_W'(ring_start_o);
        end
    end

    // A stop from the engine turns enable off unless software writes config
    p_stop_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !wr_cfg) |=> !en_o);

    // Halt requests never outlive the enable bit by more than one cycle
    p_halt_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !reg_wr) |=> (!pkt_halt_o && !brst_halt_o));

endmodule

// File: rtl/rxdma_packer.sv
// Collects stream bytes into one big-endian memory word with byte enables.
// Assumes the caller gives the lane of each byte and clears after each write.
module rxdma_packer
    import rxdma_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BPW    = DATA_W / BYTE_W,
    localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [DATA_W-1:0] word_o,
    output logic [BPW-1:0]    be_o
);

    for (genvar g = 0; g < BPW; g++) begin : g_lane
        logic [BYTE_W-1:0] b_q;
        logic              v_q;

        // One lane: lane 0 is the lowest address and the most significant byte
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                b_q <= '0;
                v_q <= 1'b0;
            end else if (push_i && (lane_i == LANE_W'(g))) begin
                b_q <= byte_i;
                v_q <= 1'b1;
            end
        end

        assign word_o[DATA_W-1-g*BYTE_W -: BYTE_W] = b_q;
        assign be_o[BPW-1-g]                        = v_q;
    end

endmodule

// File: rtl/rxdma_engine.sv
// Channel sequencer: fetches a descriptor, fills its buffer from the stream,
// writes the descriptor back and advances or wraps the pointer.
// Assumes word-aligned descriptors and buffers and a memory that holds
// request fields until it acknowledges.
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32,
    localparam int BPW    = DATA_W / BYTE_W,
    localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1,
    localparam int DESC_B = 2 * BPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              pkt_halt_i,
    input  logic              brst_halt_i,
    input  logic [ADDR_W-1:0] ring_start_i,
    input  logic              ring_load_i,
    output logic              stop_o,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BPW-1:0]    mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    rx_state_t         st, st_n;
    logic [ADDR_W-1:0] desc_ptr;
    logic [ADDR_W-1:0] buf_ptr;
    logic [LEN_W-1:0]  cap;
    logic [LEN_W-1:0]  desc_st;
    logic [LEN_W-1:0]  cnt;
    logic              ovf;
    logic              last_seen;
    logic              pk_push, pk_clr;
    logic [DATA_W-1:0] pk_word;
    logic [BPW-1:0]    pk_be;
    logic [LEN_W-1:0]  wb_status;
    logic              halt_any;
    logic              hs;
    logic              keep;

    assign halt_any = pkt_halt_i || brst_halt_i;
    assign hs       = s_valid && s_ready;
    assign keep     = cnt < cap;

    rxdma_packer #(.DATA_W(DATA_W)) u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pk_clr),
        .push_i (pk_push),
        .lane_i (cnt[LANE_W-1:0]),
        .byte_i (s_data),
        .word_o (pk_word),
        .be_o   (pk_be)
    );

    // Status returned to software: ownership back, one-buffer packet, overflow
    always_comb begin
        wb_status         = desc_st;
        wb_status[ST_OWN] = 1'b0;
        wb_status[ST_EOP] = 1'b1;
        wb_status[ST_SOP] = 1'b1;
        wb_status[ST_OVF] = ovf;
    end

    // Next state, stop pulse and packer control
    always_comb begin
        st_n    = st;
        stop_o  = 1'b0;
        pk_push = 1'b0;
        pk_clr  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (en_i && halt_any) begin
                    stop_o = 1'b1;
                end else if (en_i && s_valid) begin
                    st_n = ST_FETCH_HDR;
                end
            end
            ST_FETCH_HDR: begin
                if (mem_ack) begin
                    if (!mem_rdata[ST_OWN] || halt_any) begin
                        stop_o = 1'b1;
                        st_n   = ST_IDLE;
                    end else begin
                        st_n = ST_FETCH_PTR;
                    end
                end
            end
            ST_FETCH_PTR: begin
                if (mem_ack) begin
                    pk_clr = 1'b1;
                    st_n   = ST_RECV;
                end
            end
            ST_RECV: begin
                if (hs) begin
                    pk_push = keep;
                    if (s_last) begin
                        st_n = (keep || (pk_be != '0)) ? ST_WRITE : ST_WBACK;
                    end else if (keep && (cnt[LANE_W-1:0] == LANE_W'(BPW - 1))) begin
                        st_n = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    pk_clr = 1'b1;
                    if (last_seen) begin
                        st_n = ST_WBACK;
                    end else if (brst_halt_i) begin
                        stop_o = 1'b1;
                        st_n   = ST_IDLE;
                    end else begin
                        st_n = ST_RECV;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    stop_o = halt_any;
                    st_n   = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register and per-packet datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            desc_ptr  <= '0;
            buf_ptr   <= '0;
            cap       <= '0;
            desc_st   <= '0;
            cnt       <= '0;
            ovf       <= 1'b0;
            last_seen <= 1'b0;
        end else begin
            st <= st_n;
            if (ring_load_i) begin
                desc_ptr <= ring_start_i;
            end else if (st == ST_WBACK && mem_ack) begin
                desc_ptr <= desc_st[ST_WRAP] ? ring_start_i
                                             : desc_ptr + ADDR_W'(DESC_B);
            end
            if (st == ST_FETCH_HDR && mem_ack) begin
                cap     <= mem_rdata[DATA_W-1 -: LEN_W];
                desc_st <= mem_rdata[LEN_W-1:0];
            end
            if (st == ST_FETCH_PTR && mem_ack) begin
                buf_ptr   <= mem_rdata[ADDR_W-1:0];
                cnt       <= '0;
                ovf       <= 1'b0;
                last_seen <= 1'b0;
            end
            if (st == ST_RECV && hs) begin
                if (keep) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
                if (s_last) begin
                    last_seen <= 1'b1;
                end
            end
            if (st == ST_WRITE && mem_ack) begin
                buf_ptr <= buf_ptr + ADDR_W'(BPW);
            end
        end
    end

    // Memory port and stream handshake drive
    always_comb begin
        mem_req   = (st == ST_FETCH_HDR) || (st == ST_FETCH_PTR) ||
                    (st == ST_WRITE) || (st == ST_WBACK);
        mem_we    = (st == ST_WRITE) || (st == ST_WBACK);
        mem_addr  = desc_ptr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
        case (st)
            ST_FETCH_PTR: mem_addr = desc_ptr + ADDR_W'(BPW);
            ST_WRITE:     mem_addr = buf_ptr;
            ST_WBACK: begin
                mem_wdata = {cnt, wb_status};
                mem_be    = '1;
            end
            default: ;
        endcase
        s_ready = (st == ST_RECV);
    end

    // The stream is never accepted while a memory request is open
    p_ready_no_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !mem_req);

    // A pending request holds its fields until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // The written-back count never exceeds the buffer capacity
    p_count_in_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WBACK) |-> (cnt <= cap));

    // Byte enables of a write start at the lowest address and are contiguous
    p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_be != '0) &&
                                 (((~mem_be) & ((~mem_be) + BPW'(1))) == '0)));

    // A write-back is only reached after a descriptor was fetched as owned
    p_wb_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WBACK) |-> desc_st[ST_OWN]);

endmodule

// File: rtl/rxdma_channel.sv
// Top of the receive DMA channel: register file plus sequencer.
// Assumes software prepares descriptors before setting the enable bit.
module rxdma_channel
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32,
    parameter int REG_AW = 2,
    localparam int BPW   = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BPW-1:0]    mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              en, pkt_halt, brst_halt, ring_load, stop;
    logic [ADDR_W-1:0] ring_start;

    rxdma_regs #(.ADDR_W(ADDR_W), .REG_W(32), .REG_AW(REG_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .stop_i       (stop),
        .en_o         (en),
        .pkt_halt_o   (pkt_halt),
        .brst_halt_o  (brst_halt),
        .ring_start_o (ring_start),
        .ring_load_o  (ring_load)
    );

    rxdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .pkt_halt_i   (pkt_halt),
        .brst_halt_i  (brst_halt),
        .ring_start_i (ring_start),
        .ring_load_i  (ring_load),
        .stop_o       (stop),
        .s_valid      (s_valid),
        .s_data       (s_data),
        .s_last       (s_last),
        .s_ready      (s_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_be       (mem_be),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata)
    );

    // While disabled and between packets the stream stays stalled
    p_off_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !s_ready) |=> !s_ready);

endmodule

// File: tb/rxdma_channel_test.sv
module rxdma_channel_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        s_valid, s_last, s_ready;
    logic [7:0]  s_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] ram [0:255];
    logic        sw_we = 1'b0;
    logic [31:0] sw_a, sw_d, merged;
    int n_checks = 0, n_fail = 0, n_writes = 0, rdy_cnt = 0;
    int viol_r11 = 0, viol_r12 = 0;
    logic prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    bit done = 0;

    always #5 clk = ~clk;

    rxdma_channel uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle acknowledge, byte-enabled writes, software port
    always @(posedge clk) begin
        if (sw_we) ram[sw_a[9:2]] <= sw_d;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= ram[mem_addr[9:2]];
            if (mem_we) begin
                merged = ram[mem_addr[9:2]];
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) merged[8*b +: 8] = mem_wdata[8*b +: 8];
                ram[mem_addr[9:2]] <= merged;
                n_writes++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        prev_pend <= mem_req && !mem_ack;
        prev_addr <= mem_addr;
    end

    // Port monitors for R11 and R12
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_ready && mem_req) viol_r11++;
            if (s_ready) rdy_cnt++;
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) viol_r12++;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_a = a; sw_d = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic set_desc(input logic [31:0] d, input logic [15:0] cap,
                            input logic [15:0] st, input logic [31:0] bufa);
        sw_write(d, {cap, st});
        sw_write(d + 4, bufa);
    endtask

    // Sends n bytes first, first+1, ...; gives up after limit stalled cycles
    task automatic send(input int n, input logic [7:0] first, input int limit,
                        output int sent);
        int w;
        sent = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1; s_data = first + 8'(i); s_last = (i == n - 1);
            w = 0;
            while (!s_ready && w < limit) begin
                @(negedge clk);
                w++;
            end
            if (!s_ready) break;
            @(posedge clk);
            sent++;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(2'd0, d); check("R1", "cfg after reset", d, 32'h0);
        reg_read(2'd1, d); check("R1", "ring after reset", d, 32'h0);
        check("R1", "s_ready after reset", {31'b0, s_ready}, 32'h0);
        check("R1", "mem_req after reset", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reg_write(2'd1, 32'h100);
        reg_read(2'd1, d); check("R2", "ring start readback", d, 32'h100);
        set_desc(32'h100, 16'd16, 16'h8008, 32'h200);
        set_desc(32'h108, 16'd4,  16'h8000, 32'h300);
        set_desc(32'h110, 16'd8,  16'h9000, 32'h380);
        for (int i = 0; i < 4; i++) sw_write(32'h200 + 4*i, 32'hEEEE_EEEE);
        sw_write(32'h300, 32'h5555_5555);
        sw_write(32'h304, 32'h5555_5555);
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, d); check("R2", "enable readback", d, 32'h1);
    endtask

    task automatic t_basic();
        int sent;
        send(6, 8'hA0, 200, sent);
        check("R3", "bytes accepted", 32'(sent), 32'd6);
        wait_cycles(20);
        check("R4", "buffer word 0", ram[32'h200 >> 2], 32'hA0A1_A2A3);
        check("R4", "partial word keeps bytes", ram[32'h204 >> 2], 32'hA4A5_EEEE);
        check("R5", "write-back word", ram[32'h100 >> 2], 32'h0006_6008);
        check("R3", "buffer address word untouched", ram[32'h104 >> 2], 32'h200);
    endtask

    task automatic t_trunc();
        int sent;
        send(7, 8'hB0, 200, sent);
        check("R8", "all bytes consumed", 32'(sent), 32'd7);
        wait_cycles(20);
        check("R8", "buffer filled to capacity", ram[32'h300 >> 2], 32'hB0B1_B2B3);
        check("R8", "no write past capacity", ram[32'h304 >> 2], 32'h5555_5555);
        check("R8", "count capped and overflow flag", ram[32'h108 >> 2], 32'h0004_6001);
    endtask

    task automatic t_wrap();
        int sent;
        send(8, 8'hC8, 200, sent);
        wait_cycles(20);
        check("R6", "last descriptor buffer", ram[32'h384 >> 2], 32'hCCCD_CECF);
        check("R6", "wrap bit kept on write-back", ram[32'h110 >> 2], 32'h0008_7000);
        set_desc(32'h100, 16'd16, 16'h8000, 32'h200);
        send(3, 8'hD0, 200, sent);
        wait_cycles(20);
        check("R6", "wrapped to ring start buffer", ram[32'h200 >> 2], 32'hD0D1_D2A3);
        check("R6", "ring start descriptor written", ram[32'h100 >> 2], 32'h0003_6000);
    endtask

    task automatic t_notown();
        logic [31:0] d;
        int w0, r0, sent;
        w0 = n_writes; r0 = rdy_cnt;
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h77; s_last = 1'b0;
        wait_cycles(30);
        reg_read(2'd0, d); check("R7", "enable self-cleared", d, 32'h0);
        check("R7", "stream never ready", 32'(rdy_cnt - r0), 32'd0);
        check("R7", "no memory write", 32'(n_writes - w0), 32'd0);
        check("R7", "descriptor untouched", ram[32'h108 >> 2], 32'h0004_6001);
        s_valid = 1'b0;
        set_desc(32'h108, 16'd16, 16'h8000, 32'h300);
        reg_write(2'd0, 32'h1);
        send(2, 8'hE0, 200, sent);
        wait_cycles(20);
        check("R7", "same descriptor used after restart", ram[32'h300 >> 2], 32'hE0E1_B2B3);
        check("R7", "restart write-back", ram[32'h108 >> 2], 32'h0002_6000);
    endtask

    task automatic t_pkthalt();
        logic [31:0] d;
        int sent, w0, r0;
        set_desc(32'h110, 16'd8, 16'h9000, 32'h380);
        fork
            send(8, 8'hF0, 200, sent);
            begin wait_cycles(8); reg_write(2'd0, 32'h3); end
        join
        wait_cycles(20);
        check("R9", "packet completed", 32'(sent), 32'd8);
        check("R9", "tail word written", ram[32'h384 >> 2], 32'hF4F5_F6F7);
        check("R9", "write-back done", ram[32'h110 >> 2], 32'h0008_7000);
        reg_read(2'd0, d); check("R9", "enable reads 0", d, 32'h0);
        w0 = n_writes; r0 = rdy_cnt;
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h99; s_last = 1'b1;
        wait_cycles(20);
        s_valid = 1'b0; s_last = 1'b0;
        check("R9", "no fetch after halt", 32'(rdy_cnt - r0), 32'd0);
        check("R9", "no write after halt", 32'(n_writes - w0), 32'd0);
    endtask

    task automatic t_bursthalt();
        logic [31:0] d;
        int sent;
        set_desc(32'h100, 16'd16, 16'h8000, 32'h200);
        reg_write(2'd0, 32'h1);
        fork
            send(12, 8'h10, 10, sent);
            begin wait_cycles(8); reg_write(2'd0, 32'h5); end
        join
        wait_cycles(10);
        reg_read(2'd0, d); check("R10", "enable reads 0", d, 32'h0);
        check("R10", "no write-back, still owned", ram[32'h100 >> 2], 32'h0010_8000);
        check("R10", "first word completed", ram[32'h200 >> 2], 32'h1011_1213);
        check("R10", "packet cut short", 32'(sent < 12), 32'd1);
        check("R10", "stream stalled", {31'b0, s_ready}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        s_valid = 1'b0; s_data = '0; s_last = 1'b0;
        for (int i = 0; i < 256; i++) ram[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_trunc();
        t_wrap();
        t_notown();
        t_pkthalt();
        t_bursthalt();
        check("R11", "ready while memory busy", 32'(viol_r11), 32'd0);
        check("R12", "request dropped or changed", 32'(viol_r12), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule